// File: doc/BRIEF.md
# Packet fetch and dispatch unit

The block is the front end of a dual-issue core. Each cycle it presents one packet address to an instruction memory and receives four 16-bit instructions in a single wide word. A register stage captures the packet. In the next cycle a router sorts the instructions by class into two dispatch queues: one feeds the integer unit and one feeds the floating-point unit. Each queue drives its own ready/valid output port.

Branch instructions never leave the block. The router evaluates them against a one-bit condition input and redirects the fetch address itself, so a loop-closing branch costs the execution units no issue slot. Memory operations always go to the integer side, which computes their addresses. A memory operation that loads or stores a floating-point register also appears on the floating-point side. Fetch stops while either queue lacks room for the instructions that the held packet would give it.

Top module: `pkt_fetch_dispatch`

## Requirements
- R1: One rising edge with `rst_n` low sets `fetch_addr_o` to 0 and drives `int_valid_o` and `fp_valid_o` low.
- R2: A packet is one word from `fetch_data_i`, and slot 0 (bits 15:0) is first in program order. With no stall and no taken branch, `fetch_addr_o` rises by one packet at every clock edge.
- R3: The queues start empty and the outputs are ready. An instruction then shows on its stream output after the second rising edge that follows the edge at which its packet address first appeared on `fetch_addr_o`.
- R4: The class field is instruction bits 15:14. Value 00 goes to the integer stream and 01 to the floating-point stream. Value 10 is a memory operation: it goes to the integer stream, and also to the floating-point stream when bit 13 is 1.
- R5: A class 11 instruction (branch) never appears on either dispatch output.
- R6: A branch with bit 13 = 0 is always taken. A branch with bit 13 = 1 is taken only if `cond_i` is 1 in the cycle its packet leaves stage two. The target packet address is bits ADDR_W-1:0.
- R7: A taken branch sets `fetch_addr_o` to the target on the next edge. Instructions before the branch in its packet are dispatched. Instructions after it are squashed. The packet fetched behind it is discarded, which costs one fetch bubble. When a packet holds several taken branches, the first one in program order wins.
- R8: Each stream delivers its instructions in program order.
- R9: Each queue holds four entries. A packet stays in stage two, and `fetch_addr_o` holds, until both queues can accept all of the packet's instructions bound for them. No instruction is lost or duplicated.
- R10: While an output's valid is high and its ready is low, the valid stays high and the instruction stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr_o | output | ADDR_W | Packet address sent to instruction memory |
| fetch_data_i | input | 4*16 | Packet returned in the same cycle; slot 0 in the low bits |
| cond_i | input | 1 | Condition for conditional branches |
| int_valid_o | output | 1 | Integer stream holds an instruction |
| int_insn_o | output | 16 | Integer stream instruction |
| int_ready_i | input | 1 | Integer unit takes the instruction |
| fp_valid_o | output | 1 | Floating-point stream holds an instruction |
| fp_insn_o | output | 16 | Floating-point stream instruction |
| fp_ready_i | input | 1 | Floating-point unit takes the instruction |

## Verification
The fetch address changes one edge after a decision: it advances, holds or is redirected at the edge where stage two accepts or refuses its packet. The bench reads the address at the falling edge after that rising edge. A dispatched instruction shows two edges after its address: one edge to capture the packet and one to write the queue. The directed latency test samples exactly at those falling edges. In the random runs, ready is driven at the falling edge and valid and data are read at that same edge, so each handshake is judged by the values that the next rising edge will see. Those pops are compared in order against a program walk done in the bench.

// File: rtl/fad_pkg.sv
// Shared definitions for the packet fetch and dispatch unit.
// Assumes 16-bit instructions with the class field in the top two bits.
package fad_pkg;
    localparam int INSN_W   = 16;
    localparam int CLS_HI   = 15;
    localparam int CLS_LO   = 14;
    localparam int FLAG_BIT = 13;

    typedef enum logic [1:0] {
        CLS_INT = 2'b00,
        CLS_FP  = 2'b01,
        CLS_MEM = 2'b10,
        CLS_BR  = 2'b11
    } insn_class_e;

    function automatic insn_class_e class_of(input logic [INSN_W-1:0] ins);
        return insn_class_e'(ins[CLS_HI:CLS_LO]);
    endfunction
endpackage

// File: rtl/fad_route.sv
// Stage-two router: walks a packet in program order and builds compacted
// per-stream lists. It resolves branches and squashes the slots after the
// first taken branch. Purely combinational.
// Assumes ADDR_W <= FLAG_BIT so that the branch target fits below the flag.
module fad_route import fad_pkg::*; #(
    parameter int PKT_N  = 4,
    parameter int ADDR_W = 8,
    localparam int CNT_W = $clog2(PKT_N + 1),
    localparam int IDX_W = (PKT_N > 1) ? $clog2(PKT_N) : 1
) (
    input  logic                    pkt_valid,
    input  logic [PKT_N*INSN_W-1:0] pkt,
    input  logic                    cond_i,
    output logic [INSN_W-1:0]       int_list [PKT_N],
    output logic [CNT_W-1:0]        int_n,
    output logic [INSN_W-1:0]       fp_list [PKT_N],
    output logic [CNT_W-1:0]        fp_n,
    output logic                    br_taken,
    output logic [ADDR_W-1:0]       br_target
);
    // Classify each slot and append it to the stream lists it belongs to.
    always_comb begin
        logic [INSN_W-1:0] ins;
        logic [IDX_W-1:0]  ii;
        logic [IDX_W-1:0]  fi;
        logic              alive;
        int_n     = '0;
        fp_n      = '0;
        ii        = '0;
        fi        = '0;
        br_taken  = 1'b0;
        br_target = '0;
        alive     = pkt_valid;
        for (int k = 0; k < PKT_N; k++) begin
            int_list[k] = '0;
            fp_list[k]  = '0;
        end
        for (int i = 0; i < PKT_N; i++) begin
            ins = pkt[i*INSN_W +: INSN_W];
            if (alive) begin
                case (class_of(ins))
                    CLS_INT: begin
                        int_list[ii] = ins;
                        ii    = ii + IDX_W'(1);
                        int_n = int_n + CNT_W'(1);
                    end
                    CLS_FP: begin
                        fp_list[fi] = ins;
                        fi   = fi + IDX_W'(1);
                        fp_n = fp_n + CNT_W'(1);
                    end
                    CLS_MEM: begin
                        int_list[ii] = ins;
                        ii    = ii + IDX_W'(1);
                        int_n = int_n + CNT_W'(1);
                        if (ins[FLAG_BIT]) begin
                            fp_list[fi] = ins;
                            fi   = fi + IDX_W'(1);
                            fp_n = fp_n + CNT_W'(1);
                        end
                    end
                    default: begin
                        if (!ins[FLAG_BIT] || cond_i) begin
                            br_taken  = 1'b1;
                            br_target = ins[ADDR_W-1:0];
                            alive     = 1'b0;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/fad_queue.sv
// Dispatch queue: accepts up to PKT_N instructions per cycle in order and
// releases one per cycle through a ready/valid port.
// Assumes DEPTH is a power of two and that the writer never exceeds `space`.
module fad_queue import fad_pkg::*; #(
    parameter int DEPTH = 4,
    parameter int PKT_N = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int WN_W  = $clog2(PKT_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WN_W-1:0]   wr_n,
    input  logic [INSN_W-1:0] wr_list [PKT_N],
    input  logic              out_ready,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_data,
    output logic [CNT_W-1:0]  space
);
    logic [INSN_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_ptr;
    logic [CNT_W-1:0]  count;
    logic [WN_W-1:0]   push_n;
    logic              pop;

    // Handshake and occupancy views of the queue.
    always_comb begin
        push_n    = wr_en ? wr_n : '0;
        out_valid = (count != '0);
        pop       = out_valid && out_ready;
        out_data  = slots[rd_ptr];
        space     = CNT_W'(DEPTH) - count;
    end

    // Store the incoming instructions in consecutive free slots.
    always_ff @(posedge clk) begin
        for (int j = 0; j < PKT_N; j++) begin
            if (j < int'(push_n)) slots[wr_ptr + PTR_W'(j)] <= wr_list[j];
        end
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            rd_ptr <= rd_ptr + PTR_W'(pop);
            count  <= count + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    // R9: the writer only pushes what fits.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_n) <= int'(space));

    // R10: an offered instruction stays put until it is taken.
    p_hold_offer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/pkt_fetch_dispatch.sv
// Two-stage packet fetch and dispatch. Stage one presents the packet address
// and captures the returned packet. Stage two routes the packet into the
// integer and floating-point queues, executes branches and redirects fetch.
// Assumes the instruction memory answers in the same cycle as the address.
module pkt_fetch_dispatch import fad_pkg::*; #(
    parameter int ADDR_W  = 8,
    parameter int PKT_N   = 4,
    parameter int Q_DEPTH = 4,
    localparam int PKT_W  = PKT_N * INSN_W,
    localparam int N_W    = $clog2(PKT_N + 1),
    localparam int SP_W   = $clog2(Q_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic [PKT_W-1:0]  fetch_data_i,
    input  logic              cond_i,
    output logic              int_valid_o,
    output logic [INSN_W-1:0] int_insn_o,
    input  logic              int_ready_i,
    output logic              fp_valid_o,
    output logic [INSN_W-1:0] fp_insn_o,
    input  logic              fp_ready_i
);
    logic [ADDR_W-1:0] pc;
    logic              s2_valid;
    logic [PKT_W-1:0]  s2_pkt;
    logic [INSN_W-1:0] int_list [PKT_N];
    logic [INSN_W-1:0] fp_list [PKT_N];
    logic [N_W-1:0]    int_n;
    logic [N_W-1:0]    fp_n;
    logic              br_taken;
    logic [ADDR_W-1:0] br_target;
    logic [SP_W-1:0]   int_space;
    logic [SP_W-1:0]   fp_space;
    logic              s2_fire;
    logic              advance;

    assign fetch_addr_o = pc;

    // Stage two leaves only when both queues have room for its share.
    always_comb begin
        s2_fire = s2_valid && (int'(int_n) <= int'(int_space))
                           && (int'(fp_n) <= int'(fp_space));
        advance = !s2_valid || s2_fire;
    end

    // Fetch address and stage-two packet register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            s2_valid <= 1'b0;
            s2_pkt   <= '0;
        end else if (s2_fire && br_taken) begin
            pc       <= br_target;
            s2_valid <= 1'b0;
        end else if (advance) begin
            pc       <= pc + ADDR_W'(1);
            s2_valid <= 1'b1;
            s2_pkt   <= fetch_data_i;
        end
    end

    fad_route #(.PKT_N(PKT_N), .ADDR_W(ADDR_W)) u_route (
        .pkt_valid (s2_valid),
        .pkt       (s2_pkt),
        .cond_i    (cond_i),
        .int_list  (int_list),
        .int_n     (int_n),
        .fp_list   (fp_list),
        .fp_n      (fp_n),
        .br_taken  (br_taken),
        .br_target (br_target)
    );

    fad_queue #(.DEPTH(Q_DEPTH), .PKT_N(PKT_N)) u_int_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (s2_fire),
        .wr_n      (int_n),
        .wr_list   (int_list),
        .out_ready (int_ready_i),
        .out_valid (int_valid_o),
        .out_data  (int_insn_o),
        .space     (int_space)
    );

    fad_queue #(.DEPTH(Q_DEPTH), .PKT_N(PKT_N)) u_fp_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (s2_fire),
        .wr_n      (fp_n),
        .wr_list   (fp_list),
        .out_ready (fp_ready_i),
        .out_valid (fp_valid_o),
        .out_data  (fp_insn_o),
        .space     (fp_space)
    );

    // R9: a refused packet holds both the fetch address and stage two.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid && !s2_fire |=> $stable(pc) && s2_valid);

    // R7: a taken branch redirects fetch and drops the packet behind it.
    p_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s2_fire && br_taken |=> (pc == $past(br_target)) && !s2_valid);

    // R5: branches never reach the integer stream.
    p_fold_int_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid_o |-> int_insn_o[CLS_HI:CLS_LO] != CLS_BR);

    // R5: branches never reach the floating-point stream.
    p_fold_fp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fp_valid_o |-> fp_insn_o[CLS_HI:CLS_LO] != CLS_BR);
endmodule

// File: tb/sim_pkt_fetch_dispatch.sv
`timescale 1ns/1ps
module sim_pkt_fetch_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  fetch_addr;
    logic [63:0] fetch_data;
    logic        cond = 1'b0;
    logic        int_valid, fp_valid;
    logic [15:0] int_insn, fp_insn;
    logic        int_ready = 1'b0, fp_ready = 1'b0;

    logic [63:0] imem [256];
    logic [15:0] exp_int [2048];
    logic [15:0] exp_fp  [2048];
    int n_ei, n_ef, gi, gf;
    int n_checks = 0, n_errors = 0, cyc = 0;
    bit done = 0;

    assign fetch_data = imem[fetch_addr];

    always #4 clk = ~clk;

    pkt_fetch_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .fetch_addr_o(fetch_addr),
        .fetch_data_i(fetch_data), .cond_i(cond),
        .int_valid_o(int_valid), .int_insn_o(int_insn), .int_ready_i(int_ready),
        .fp_valid_o(fp_valid), .fp_insn_o(fp_insn), .fp_ready_i(fp_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] c, input logic f,
                                       input logic [12:0] p);
        return {c, f, p};
    endfunction

    function automatic logic [15:0] rand_insn();
        int r = $urandom % 8;
        logic [1:0] c = (r < 3) ? 2'b00 : (r < 5) ? 2'b01 : (r < 7) ? 2'b10 : 2'b11;
        return mk(c, 1'($urandom), 13'($urandom));
    endfunction

    // Program walk from the requirements: routing, folding, squash, redirect.
    task automatic build_expect(input logic c);
        logic [7:0] p = 8'd0;
        n_ei = 0; n_ef = 0; gi = 0; gf = 0;
        for (int k = 0; k < 4000 && (n_ei < 2000 || n_ef < 2000); k++) begin
            logic taken = 1'b0;
            logic [7:0] nxt = p + 8'd1;
            for (int s = 0; s < 4; s++) begin
                logic [15:0] ins = imem[p][s*16 +: 16];
                if (!taken) begin
                    case (ins[15:14])
                        2'b00: if (n_ei < 2048) begin exp_int[n_ei] = ins; n_ei++; end
                        2'b01: if (n_ef < 2048) begin exp_fp[n_ef] = ins; n_ef++; end
                        2'b10: begin
                            if (n_ei < 2048) begin exp_int[n_ei] = ins; n_ei++; end
                            if (ins[13] && n_ef < 2048) begin exp_fp[n_ef] = ins; n_ef++; end
                        end
                        default: if (!ins[13] || c) begin taken = 1'b1; nxt = ins[7:0]; end
                    endcase
                end
            end
            p = nxt;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; int_ready = 1'b0; fp_ready = 1'b0;
        @(negedge clk);
        check(fetch_addr == 8'd0, "R1", "fetch address after reset", 32'(fetch_addr), 0);
        check(!int_valid && !fp_valid, "R1", "valids after reset",
              {30'd0, int_valid, fp_valid}, 0);
    endtask

    // Random ready; each handshake is judged at the falling edge before it.
    task automatic run(input int cycles, input int pct);
        for (int t = 0; t < cycles; t++) begin
            @(negedge clk);
            int_ready = ($urandom % 100) < pct;
            fp_ready  = ($urandom % 100) < pct;
            if (int_valid && int_ready) begin
                check(int_insn[15:14] != 2'b11, "R5", "branch on int stream", 32'(int_insn), 0);
                check(gi < n_ei && int_insn == exp_int[gi], "R4,R6,R7,R8",
                      "int stream order", 32'(int_insn), 32'(exp_int[gi]));
                gi++;
            end
            if (fp_valid && fp_ready) begin
                check(fp_insn[15:14] != 2'b11, "R5", "branch on fp stream", 32'(fp_insn), 0);
                check(gf < n_ef && fp_insn == exp_fp[gf], "R4,R6,R7,R8",
                      "fp stream order", 32'(fp_insn), 32'(exp_fp[gf]));
                gf++;
            end
        end
        check(gi + gf > 20, "R2", "fetch keeps making progress", 32'(gi + gf), 21);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                done = 1;
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual %0d expected below 150000", cyc);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [15:0] a, b, c, br;
        logic [7:0] held;
        void'($urandom(32'h5eed));
        for (int i = 0; i < 256; i++) imem[i] = '0;
        do_reset();

        // Directed latency, routing and redirect: packet 0 loops on itself.
        a  = mk(2'b00, 1'b0, 13'h0a1);
        b  = mk(2'b01, 1'b0, 13'h0b2);
        c  = mk(2'b10, 1'b1, 13'h0c3);
        br = mk(2'b11, 1'b0, 13'h000);
        imem[0] = {br, c, b, a};
        imem[1] = {4{mk(2'b00, 1'b0, 13'h1ee)}};
        int_ready = 1'b1; fp_ready = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check(fetch_addr == 8'd1, "R2", "address steps by one packet", 32'(fetch_addr), 1);
        check(!int_valid, "R3", "no dispatch one edge after fetch", 32'(int_valid), 0);
        @(negedge clk);
        check(int_valid && int_insn == a, "R3", "int out two edges after fetch", 32'(int_insn), 32'(a));
        check(fp_valid && fp_insn == b, "R4", "fp class routed to fp", 32'(fp_insn), 32'(b));
        check(fetch_addr == 8'd0, "R7", "redirect to branch target", 32'(fetch_addr), 0);
        @(negedge clk);
        check(int_insn == c, "R4", "memory op on int stream", 32'(int_insn), 32'(c));
        check(fp_insn == c, "R4", "fp memory op also on fp stream", 32'(fp_insn), 32'(c));
        check(fetch_addr == 8'd1, "R7", "bubble then target refetched", 32'(fetch_addr), 1);

        // Backpressure: integer-only straight-line code with readies low.
        do_reset();
        for (int p = 0; p < 256; p++)
            for (int s = 0; s < 4; s++)
                imem[p][s*16 +: 16] = mk(2'b00, 1'b0, 13'(p * 4 + s));
        cond = 1'b0;
        build_expect(1'b0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(fetch_addr == 8'd2, "R9", "fetch stalls on full queue", 32'(fetch_addr), 2);
        check(int_valid && int_insn == exp_int[0], "R10", "head offered", 32'(int_insn), 32'(exp_int[0]));
        held = fetch_addr;
        repeat (5) @(negedge clk);
        check(fetch_addr == held, "R9", "address held while stalled", 32'(fetch_addr), 32'(held));
        check(int_valid && int_insn == exp_int[0], "R10", "offer stable while not ready",
              32'(int_insn), 32'(exp_int[0]));
        run(800, 70);

        // Random programs under both condition values and two ready rates.
        for (int ph = 0; ph < 4; ph++) begin
            do_reset();
            for (int p = 0; p < 256; p++)
                for (int s = 0; s < 4; s++) imem[p][s*16 +: 16] = rand_insn();
            cond = ph[0];
            build_expect(cond);
            rst_n = 1'b1;
            run(1000, (ph < 2) ? 80 : 30);
        end

        do_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule